// File: doc/BRIEF.md
# Two-Group Reverse Power-Down Slot Sequencer

This block drives the enable lines of thirteen power slots, numbered 0 to 12, and turns them off in descending order when a shutdown is requested. A programmable index splits the slots into two groups. Slots 0 up to that index form the primary group, and the slots above it form the secondary group. After reset every slot is on. Each pulse of a step tick from a timing source turns exactly one slot off, so the timing source sets the spacing between slots.

Shutdown has two stages. In the first stage the secondary group unwinds from slot 12 down to the slot just above the primary index, and the block then rests in a monitoring phase with only the primary slots on. In the second stage the primary group unwinds from its top slot down to slot 0. When slot 0 turns off, the block raises a one-cycle done pulse and stays off until the next reset.

Each group has two request sources: an external pin and a control bit. The group's enable holds only while both sources are high. The sequence only ever removes power. It never turns a slot back on.

Top module: `pwr_slot_unwinder`

## Requirements
- R1: After a synchronous active-low reset, all 13 `slot_on` bits are 1, `phase` is 2'b00 (full-on) and `done` is 0.
- R2: A secondary request is `en2_pin` low or `sec_bit` low. A primary request is `en_pin` low or `sw_bit` low. A request seen at a clock edge starts the sequence at that edge. The first slot is cleared by a tick sampled at a later edge.
- R3: During the secondary stage, `phase` is 2'b10. Each tick clears the highest secondary slot still on, starting with slot 12. After the tick that clears slot `last_pri`+1, `phase` becomes 2'b01 and exactly slots 0..`last_pri` remain on.
- R4: A primary request seen in the monitoring phase starts the primary stage (`phase` 2'b10). Ticks then clear slot `last_pri` first and step down to slot 0. After slot 0 clears, `phase` is 2'b11 (off).
- R5: At most one slot turns off per tick. No slot changes in a cycle without a tick. A slot that is off never turns back on.
- R6: A primary request that arrives while secondary slots are on first runs the full secondary stage. Only then does the primary stage begin.
- R7: `done` is high for exactly one cycle, in the same cycle that `slot_on[0]` first reads 0.
- R8: `last_pri` is captured when shutdown starts. Changing it afterwards does not alter the split.
- R9: A `last_pri` value of 12 or above acts as 12. A request in the full-on phase then moves directly to the monitoring phase with every slot still on and no tick consumed.
- R10: Once shutdown has started, restoring the pins and bits has no effect. The off phase holds all slots off regardless of ticks until reset.
- R11: A tick that arrives in the full-on or monitoring phase changes no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_pin | input | 1 | Primary group enable pin, low requests shutdown |
| en2_pin | input | 1 | Secondary group enable pin, low requests shutdown |
| sw_bit | input | 1 | Primary software enable bit, 0 requests shutdown |
| sec_bit | input | 1 | Secondary software enable bit, 0 requests shutdown |
| last_pri | input | 4 | Index of the highest primary slot |
| step_tick | input | 1 | One-cycle advance pulse |
| slot_on | output | 13 | Registered per-slot enables, bit i for slot i |
| phase | output | 2 | 00 full-on, 01 primary monitoring, 10 powering down, 11 off |
| done | output | 1 | One-cycle pulse when slot 0 turns off |

## Verification
The full sequence is run for several split points: index 0 (a secondary group of twelve slots), index 11 (one secondary slot), index 12 (no secondary slot), and middle values. These runs show that the stop point between the two stages follows the programmed index. Each run uses either the pin or the control bit as its request source, which shows that either source alone starts a stage. Some runs drop the primary request together with the secondary one, which separates a design that waits for the secondary stage from one that jumps ahead. Directed cases then change the index during the secondary stage, restore the enables during the sequence, and send ticks in the resting phases, which confirms that none of these has an effect.

// File: rtl/pwr_unwind_pkg.sv
// Shared types for the reverse power-down slot sequencer.
// Assumes: state and phase codes are used only inside this block and at its phase port.
package pwr_unwind_pkg;

    typedef enum logic [2:0] {
        ST_FULL     = 3'd0,
        ST_SEC_DOWN = 3'd1,
        ST_PRI_MON  = 3'd2,
        ST_PRI_DOWN = 3'd3,
        ST_OFF      = 3'd4
    } unwind_state_e;

    typedef enum logic [1:0] {
        PH_FULL = 2'b00,
        PH_MON  = 2'b01,
        PH_DOWN = 2'b10,
        PH_OFF  = 2'b11
    } unwind_phase_e;

endpackage

// File: rtl/unwind_req.sv
// Request qualifier: merges each group's pin and control bit into one shutdown
// request and clamps the primary index to the highest slot number.
// Assumes: inputs are already synchronous to clk.
module unwind_req #(
    parameter int NUM_SLOTS = 13,
    parameter int IDX_W     = 4
) (
    input  logic             en_pin,
    input  logic             en2_pin,
    input  logic             sw_bit,
    input  logic             sec_bit,
    input  logic [IDX_W-1:0] last_pri,
    output logic             sec_drop,
    output logic             pri_drop,
    output logic [IDX_W-1:0] lp_clamped
);
    localparam int TOP_IDX = NUM_SLOTS - 1;

    // A group stays up only while both of its sources hold it enabled.
    always_comb begin
        sec_drop = !(en2_pin && sec_bit);
        pri_drop = !(en_pin && sw_bit);
    end

    // Out-of-range index values mean every slot is primary.
    always_comb begin
        if (last_pri > IDX_W'(TOP_IDX))
            lp_clamped = IDX_W'(TOP_IDX);
        else
            lp_clamped = last_pri;
    end

endmodule

// File: rtl/unwind_fsm.sv
// Two-stage unwind controller. It holds the phase, the pointer to the next
// slot to clear and the split index captured at shutdown start.
// Assumes: step_tick is a single-cycle pulse and lp_in is at most NUM_SLOTS-1.
module unwind_fsm
    import pwr_unwind_pkg::*;
#(
    parameter int NUM_SLOTS = 13,
    parameter int IDX_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_drop,
    input  logic             pri_drop,
    input  logic [IDX_W-1:0] lp_in,
    input  logic             step_tick,
    output unwind_state_e    state,
    output logic             clr_en,
    output logic [IDX_W-1:0] clr_idx,
    output logic             done
);
    localparam int TOP_IDX = NUM_SLOTS - 1;

    unwind_state_e    state_q;
    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] lp_q;
    logic             done_q;

    // A clear happens only on a tick while one of the two stages is active.
    always_comb begin
        clr_en  = step_tick && (state_q == ST_SEC_DOWN || state_q == ST_PRI_DOWN);
        clr_idx = ptr_q;
    end

    // Phase transitions, pointer stepping and done pulse generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FULL;
            ptr_q   <= IDX_W'(TOP_IDX);
            lp_q    <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_FULL: begin
                    if (sec_drop || pri_drop) begin
                        lp_q  <= lp_in;
                        ptr_q <= IDX_W'(TOP_IDX);
                        if (lp_in == IDX_W'(TOP_IDX))
                            state_q <= ST_PRI_MON;
                        else
                            state_q <= ST_SEC_DOWN;
                    end
                end
                ST_SEC_DOWN: begin
                    if (step_tick) begin
                        if (ptr_q == lp_q + IDX_W'(1))
                            state_q <= ST_PRI_MON;
                        else
                            ptr_q <= ptr_q - IDX_W'(1);
                    end
                end
                ST_PRI_MON: begin
                    if (pri_drop) begin
                        ptr_q   <= lp_q;
                        state_q <= ST_PRI_DOWN;
                    end
                end
                ST_PRI_DOWN: begin
                    if (step_tick) begin
                        if (ptr_q == '0) begin
                            state_q <= ST_OFF;
                            done_q  <= 1'b1;
                        end else begin
                            ptr_q <= ptr_q - IDX_W'(1);
                        end
                    end
                end
                default: state_q <= ST_OFF;
            endcase
        end
    end

    assign state = state_q;
    assign done  = done_q;

    AST_PRI_STAGE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRI_DOWN && $past(state_q) == ST_PRI_MON) |-> $past(pri_drop)); // R4

    AST_SEC_PTR_ABOVE_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEC_DOWN) |-> (ptr_q > lp_q)); // R3

    AST_SPLIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) != ST_FULL) |-> $stable(lp_q)); // R8

endmodule

// File: rtl/slot_bank.sv
// Registered per-slot enables. A slot clears when the controller names it
// together with a clear strobe, and it never sets again until reset.
// Assumes: clr_idx addresses one slot within range.
module slot_bank #(
    parameter int NUM_SLOTS = 13,
    parameter int IDX_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_en,
    input  logic [IDX_W-1:0]     clr_idx,
    output logic [NUM_SLOTS-1:0] slot_q
);
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        logic bit_q;
        // Slot i holds power from reset until its clear is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bit_q <= 1'b1;
            else if (clr_en && clr_idx == IDX_W'(i))
                bit_q <= 1'b0;
        end
        assign slot_q[i] = bit_q;
    end

    AST_CLR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |-> (clr_idx < IDX_W'(NUM_SLOTS))); // R5

endmodule

// File: rtl/pwr_slot_unwinder.sv
// Top of the reverse power-down slot sequencer. It joins the request
// qualifier, the unwind controller and the slot enable registers, and maps the
// controller state to the external phase code.
// Assumes: step_tick pulses last one cycle. Power-up after shutdown needs a reset.
module pwr_slot_unwinder
    import pwr_unwind_pkg::*;
#(
    parameter int NUM_SLOTS = 13,
    parameter int IDX_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_pin,
    input  logic                 en2_pin,
    input  logic                 sw_bit,
    input  logic                 sec_bit,
    input  logic [IDX_W-1:0]     last_pri,
    input  logic                 step_tick,
    output logic [NUM_SLOTS-1:0] slot_on,
    output logic [1:0]           phase,
    output logic                 done
);
    logic             sec_drop;
    logic             pri_drop;
    logic [IDX_W-1:0] lp_clamped;
    unwind_state_e    state;
    logic             clr_en;
    logic [IDX_W-1:0] clr_idx;

    unwind_req #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_req (
        .en_pin     (en_pin),
        .en2_pin    (en2_pin),
        .sw_bit     (sw_bit),
        .sec_bit    (sec_bit),
        .last_pri   (last_pri),
        .sec_drop   (sec_drop),
        .pri_drop   (pri_drop),
        .lp_clamped (lp_clamped)
    );

    unwind_fsm #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_drop  (sec_drop),
        .pri_drop  (pri_drop),
        .lp_in     (lp_clamped),
        .step_tick (step_tick),
        .state     (state),
        .clr_en    (clr_en),
        .clr_idx   (clr_idx),
        .done      (done)
    );

    slot_bank #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_en  (clr_en),
        .clr_idx (clr_idx),
        .slot_q  (slot_on)
    );

    // Map controller state to the externally visible phase code.
    always_comb begin
        unique case (state)
            ST_FULL:                  phase = PH_FULL;
            ST_PRI_MON:               phase = PH_MON;
            ST_SEC_DOWN, ST_PRI_DOWN: phase = PH_DOWN;
            default:                  phase = PH_OFF;
        endcase
    end

    AST_SLOTS_ONLY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_on & ~$past(slot_on)) == '0); // R5

    AST_ONE_PER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $countones($past(slot_on) & ~slot_on) <= ($past(step_tick) ? 1 : 0)); // R5

    AST_DONE_WITH_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(slot_on[0]) && !slot_on[0])); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_SEC_BEFORE_PRI: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(slot_on[0]) |-> (slot_on == '0)); // R6

endmodule

// File: tb/tb_pwr_slot_unwinder.sv
module tb_pwr_slot_unwinder;
    localparam int PERIOD = 10;
    localparam int NS     = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en_pin = 1'b1, en2_pin = 1'b1, sw_bit = 1'b1, sec_bit = 1'b1;
    logic [3:0]    last_pri = 4'd0;
    logic          step_tick = 1'b0;
    logic [NS-1:0] slot_on;
    logic [1:0]    phase;
    logic          done;

    int n_chk = 0;
    int n_bad = 0;

    pwr_slot_unwinder dut (
        .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .en2_pin(en2_pin),
        .sw_bit(sw_bit), .sec_bit(sec_bit), .last_pri(last_pri),
        .step_tick(step_tick), .slot_on(slot_on), .phase(phase), .done(done)
    );

    always #(PERIOD/2) clk = ~clk;

    // Vector: {last_pri[3:0], sec_by_pin, pri_by_pin, pri_early}
    localparam logic [6:0] VEC [6] = '{
        {4'd0,  1'b1, 1'b1, 1'b0},
        {4'd5,  1'b0, 1'b0, 1'b0},
        {4'd11, 1'b1, 1'b0, 1'b1},
        {4'd3,  1'b0, 1'b1, 1'b1},
        {4'd7,  1'b1, 1'b1, 1'b0},
        {4'd12, 1'b0, 1'b1, 1'b0}
    };

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic t);
        @(negedge clk);
        step_tick = t;
        @(posedge clk);
        #(PERIOD/4);
    endtask

    task automatic do_reset();
        en_pin = 1'b1; en2_pin = 1'b1; sw_bit = 1'b1; sec_bit = 1'b1;
        rst_n = 1'b0;
        cyc(0);
        cyc(0);
        rst_n = 1'b1;
    endtask

    task automatic run_vec(input logic [3:0] lp, input logic sp, input logic pp, input logic early);
        logic [NS-1:0] expm;
        int nsec;
        do_reset();
        last_pri = lp;
        cyc(0);
        chk(slot_on == '1 && phase == 2'b00 && !done, "R1", {slot_on, phase, done}, {13'h1fff, 3'b000});
        if (sp) en2_pin = 1'b0; else sec_bit = 1'b0;
        if (early) begin
            if (pp) en_pin = 1'b0; else sw_bit = 1'b0;
        end
        cyc(0);
        expm = '1;
        nsec = 12 - int'(lp);
        if (nsec == 0)
            chk(phase == 2'b01 && slot_on == '1, "R9", {slot_on, phase}, {13'h1fff, 2'b01});
        else
            chk(phase == 2'b10 && slot_on == '1, "R2", {slot_on, phase}, {13'h1fff, 2'b10});
        for (int k = 0; k < nsec; k++) begin
            cyc(1);
            expm[12-k] = 1'b0;
            chk(slot_on == expm && phase == ((k == nsec-1) ? 2'b01 : 2'b10),
                "R3", {slot_on, phase}, {expm, ((k == nsec-1) ? 2'b01 : 2'b10)});
        end
        if (!early) begin
            if (pp) en_pin = 1'b0; else sw_bit = 1'b0;
        end
        cyc(1);
        chk(slot_on == expm && phase == 2'b10, "R11", {slot_on, phase}, {expm, 2'b10});
        for (int k = int'(lp); k >= 0; k--) begin
            cyc(1);
            expm[k] = 1'b0;
            chk(slot_on == expm, "R4", slot_on, expm);
            if (k == 0)
                chk(done && phase == 2'b11, "R7", {done, phase}, 3'b111);
            else
                chk(!done && phase == 2'b10, "R6", {done, phase}, 3'b010);
        end
        cyc(0);
        chk(!done && slot_on == '0, "R7", {done, slot_on}, 0);
    endtask

    initial begin
        #(PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [NS-1:0] m;
        foreach (VEC[i]) run_vec(VEC[i][6:3], VEC[i][2], VEC[i][1], VEC[i][0]);

        // R10: the off phase holds after the enables are restored.
        en_pin = 1'b1; en2_pin = 1'b1; sw_bit = 1'b1; sec_bit = 1'b1;
        cyc(1); cyc(1);
        chk(slot_on == '0 && phase == 2'b11, "R10", {slot_on, phase}, 2'b11);

        // R11: ticks in the full-on phase change nothing.
        do_reset();
        cyc(1); cyc(1);
        chk(slot_on == '1 && phase == 2'b00, "R11", {slot_on, phase}, {13'h1fff, 2'b00});

        // R10 and R5: restoring the enables mid-stage has no effect, and no tick means no change.
        last_pri = 4'd4;
        en2_pin = 1'b0;
        cyc(0);
        cyc(1); cyc(1); cyc(1);
        en2_pin = 1'b1;
        cyc(0); cyc(0);
        m = 13'h03ff;
        chk(slot_on == m && phase == 2'b10, "R10", {slot_on, phase}, {m, 2'b10});
        chk(!done, "R5", done, 0);

        // R8: an index change after the start is ignored.
        do_reset();
        last_pri = 4'd6;
        sec_bit = 1'b0;
        cyc(0);
        last_pri = 4'd2;
        for (int k = 0; k < 6; k++) cyc(1);
        m = 13'h007f;
        chk(slot_on == m && phase == 2'b01, "R8", {slot_on, phase}, {m, 2'b01});

        // R9: an index above 12 acts as 12, so slot 12 is the first primary slot cleared.
        do_reset();
        last_pri = 4'd15;
        en2_pin = 1'b0;
        cyc(0);
        chk(slot_on == '1 && phase == 2'b01, "R9", {slot_on, phase}, {13'h1fff, 2'b01});
        en_pin = 1'b0;
        cyc(0);
        cyc(1);
        m = 13'h0fff;
        chk(slot_on == m && phase == 2'b10, "R9", {slot_on, phase}, {m, 2'b10});

        // R1: reset restores every slot.
        do_reset();
        cyc(0);
        chk(slot_on == '1 && phase == 2'b00 && !done, "R1", {slot_on, phase, done}, {13'h1fff, 3'b000});

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule